// File: doc/BRIEF.md
# Packet Payload Statistics Monitor

This block watches a 64-bit AXI-Stream link that carries header-framed packets. It only listens. Every input, `mon_tready` included, is sampled, and the block drives nothing back onto the link. A beat exists only in a cycle where valid and ready are both high.

The first beat of each packet is the header. The block decodes its fields. If the header's has-time bit is set, the next beat is taken as a timestamp. Neither of these beats counts towards the statistics. Every later beat is payload, and over the payload the block keeps five figures:
- a beat count
- a wrapping 64-bit sum
- an unsigned minimum
- an unsigned maximum
- an XOR checksum

When a beat carrying tlast is accepted, the decoded header, the timestamp and the five figures are registered onto the report outputs. A one-cycle `stats_valid` strobe follows, and the accumulators restart for the next packet.

A small state machine tracks the position within a packet. It has three states:
- `ST_HDR`: waiting for a header beat.
- `ST_TIME`: waiting for the timestamp beat.
- `ST_BODY`: taking payload beats.

Its transitions are:
- `HDR_TO_TIME`: header beat, has-time set, no tlast.
- `HDR_TO_BODY`: header beat, has-time clear, no tlast.
- `HDR_ONLY`: header beat with tlast; the state stays in `ST_HDR`.
- `TIME_TO_BODY`: timestamp beat without tlast.
- `TIME_END`: timestamp beat with tlast; back to `ST_HDR`.
- `BODY_END`: payload beat with tlast; back to `ST_HDR`.

Top module: `pkt_stat_monitor`

## Requirements
- R1: A beat is taken only in a cycle where `mon_tvalid` and `mon_tready` are both high. Data presented while ready is low has no effect on any report.
- R2: The header beat is decoded as follows, and the fields are reported on the matching outputs:

  | Bits | Field | Output |
  |---|---|---|
  | [63:62] | kind | `rpt_kind` |
  | [61] | has-time flag | `rpt_has_ts` |
  | [60] | end-of-burst flag | `rpt_end_burst` |
  | [59:48] | sequence number | `rpt_seq` |
  | [47:32] | length | `rpt_len` |
  | [31:16] | source | `rpt_src` |
  | [15:0] | destination | `rpt_dst` |

- R3: When the has-time flag is 1, the beat after the header is reported on `rpt_ts` and is excluded from the statistics. When the flag is 0, `rpt_ts` reports 0.
- R4: `rpt_count` (32 bits) equals the number of payload beats in the packet.
- R5: `rpt_sum` is the sum of the payload words modulo 2^64.
- R6: `rpt_min` and `rpt_max` are unsigned extremes of the payload words. Before the first payload beat they start at 0x7FFF_FFFF_FFFF_FFFF and 0 respectively, so a packet whose words all exceed 0x7FFF_FFFF_FFFF_FFFF reports that starting value as its minimum.
- R7: `rpt_xor` is the bitwise XOR of all payload words.
- R8: `stats_valid` is high for exactly the one cycle after each tlast beat, and is low otherwise. The report outputs hold their values until the next report. After reset `stats_valid` and all report outputs are 0.
- R9: A packet with no payload reports count 0, sum 0, XOR 0, min 0x7FFF_FFFF_FFFF_FFFF and max 0. This covers a header-only packet and a packet of header plus timestamp.
- R10: The accumulators restart in the cycle after the tlast beat. A packet whose header arrives in that same cycle is reported independently of the previous packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_tdata | input | 64 | Observed stream data |
| mon_tvalid | input | 1 | Observed valid |
| mon_tready | input | 1 | Observed ready (sampled only) |
| mon_tlast | input | 1 | Observed end of packet |
| stats_valid | output | 1 | One-cycle report strobe |
| rpt_kind | output | 2 | Header kind field |
| rpt_has_ts | output | 1 | Header has-time flag |
| rpt_end_burst | output | 1 | Header end-of-burst flag |
| rpt_seq | output | 12 | Header sequence number |
| rpt_len | output | 16 | Header length field |
| rpt_src | output | 16 | Header source id |
| rpt_dst | output | 16 | Header destination id |
| rpt_ts | output | 64 | Timestamp, or 0 when absent |
| rpt_count | output | 32 | Payload beat count |
| rpt_sum | output | 64 | Payload sum modulo 2^64 |
| rpt_min | output | 64 | Unsigned payload minimum |
| rpt_max | output | 64 | Unsigned payload maximum |
| rpt_xor | output | 64 | XOR checksum of payload |

## Verification
Two things can fall in the same cycle: the report strobe for one packet, which is also when its accumulators restart, and the header beat of the next packet, which must be decoded and latched.

The bench provokes this by driving packets back to back with no idle beat between them. One such sequence is a payload packet followed at once by a header-only packet, which gives two strobes in consecutive cycles. A packet with one payload beat follows, so its header beat falls in the second strobe cycle.

Each follow-on report is judged against values computed for that packet alone, and the strobe is checked to fall low after a lone report.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;

    localparam int HDR_W = 64;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_TIME = 2'd1,
        ST_BODY = 2'd2
    } mon_state_e;

    // Header layout, MSB first; the fields are decoded by position.
    typedef struct packed {
        logic [1:0]  kind;
        logic        has_ts;
        logic        end_burst;
        logic [11:0] seq;
        logic [15:0] len;
        logic [15:0] src;
        logic [15:0] dst;
    } hdr_t;

    function automatic hdr_t decode_hdr(input logic [HDR_W-1:0] w);
        return hdr_t'(w);
    endfunction

endpackage

// File: rtl/pkt_stat_fsm.sv
module pkt_stat_fsm
    import pkt_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic last,
    input  logic has_ts_bit,
    output logic hdr_beat,
    output logic ts_beat,
    output logic pay_beat,
    output logic pkt_end
);

    mon_state_e state_q, state_d;

    // Next-state logic and state register
    always_comb begin
        state_d = state_q;
        if (beat) begin
            unique case (state_q)
                ST_HDR: begin
                    if (last)            state_d = ST_HDR;   // HDR_ONLY
                    else if (has_ts_bit) state_d = ST_TIME;  // HDR_TO_TIME
                    else                 state_d = ST_BODY;  // HDR_TO_BODY
                end
                ST_TIME: state_d = last ? ST_HDR : ST_BODY;  // TIME_END / TIME_TO_BODY
                ST_BODY: state_d = last ? ST_HDR : ST_BODY;  // BODY_END
                default: state_d = ST_HDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HDR;
        else        state_q <= state_d;
    end

    // Beat classification outputs
    always_comb begin
        hdr_beat = 1'b0;
        ts_beat  = 1'b0;
        pay_beat = 1'b0;
        unique case (state_q)
            ST_HDR:  hdr_beat = beat;
            ST_TIME: ts_beat  = beat;
            ST_BODY: pay_beat = beat;
            default: ;
        endcase
        pkt_end = beat & last;
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_HDR, ST_TIME, ST_BODY}); // R3

    AST_TIME_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_beat && !last && !has_ts_bit) |=> (state_q == ST_BODY)); // R3

endmodule

// File: rtl/pkt_stat_accum.sv
module pkt_stat_accum #(
    parameter int WORD_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              clear,
    input  logic [WORD_W-1:0] din,
    output logic [CNT_W-1:0]  nxt_count,
    output logic [WORD_W-1:0] nxt_sum,
    output logic [WORD_W-1:0] nxt_min,
    output logic [WORD_W-1:0] nxt_max,
    output logic [WORD_W-1:0] nxt_xor
);

    localparam logic [WORD_W-1:0] MIN_INIT = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] MAX_INIT = '0;

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sum_q, min_q, max_q, xor_q;

    // Values including the current beat, used both for update and report.
    always_comb begin
        nxt_count = cnt_q;
        nxt_sum   = sum_q;
        nxt_min   = min_q;
        nxt_max   = max_q;
        nxt_xor   = xor_q;
        if (take) begin
            nxt_count = cnt_q + 1'b1;
            nxt_sum   = sum_q + din;
            nxt_min   = (din < min_q) ? din : min_q;
            nxt_max   = (din > max_q) ? din : max_q;
            nxt_xor   = xor_q ^ din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sum_q <= '0;
            min_q <= MIN_INIT;
            max_q <= MAX_INIT;
            xor_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            sum_q <= '0;
            min_q <= MIN_INIT;
            max_q <= MAX_INIT;
            xor_q <= '0;
        end else begin
            cnt_q <= nxt_count;
            sum_q <= nxt_sum;
            min_q <= nxt_min;
            max_q <= nxt_max;
            xor_q <= nxt_xor;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clear) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R4

    AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (min_q <= max_q || min_q == MIN_INIT)); // R6

    AST_CLEAR_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0 && sum_q == '0 && xor_q == '0 &&
                   min_q == MIN_INIT && max_q == MAX_INIT)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clear) |=> $stable(cnt_q) && $stable(sum_q) && $stable(xor_q)); // R1

endmodule

// File: rtl/pkt_stat_monitor.sv
module pkt_stat_monitor
    import pkt_stat_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mon_tdata,
    input  logic              mon_tvalid,
    input  logic              mon_tready,
    input  logic              mon_tlast,
    output logic              stats_valid,
    output logic [1:0]        rpt_kind,
    output logic              rpt_has_ts,
    output logic              rpt_end_burst,
    output logic [11:0]       rpt_seq,
    output logic [15:0]       rpt_len,
    output logic [15:0]       rpt_src,
    output logic [15:0]       rpt_dst,
    output logic [WORD_W-1:0] rpt_ts,
    output logic [CNT_W-1:0]  rpt_count,
    output logic [WORD_W-1:0] rpt_sum,
    output logic [WORD_W-1:0] rpt_min,
    output logic [WORD_W-1:0] rpt_max,
    output logic [WORD_W-1:0] rpt_xor
);

    localparam logic [WORD_W-1:0] MIN_INIT = {1'b0, {(WORD_W-1){1'b1}}};

    logic beat;
    logic hdr_beat, ts_beat, pay_beat, pkt_end;
    hdr_t hdr_now, hdr_q, hdr_sel;
    logic [WORD_W-1:0] ts_q, ts_sel;
    logic [CNT_W-1:0]  a_count;
    logic [WORD_W-1:0] a_sum, a_min, a_max, a_xor;

    assign beat    = mon_tvalid & mon_tready;
    assign hdr_now = decode_hdr(mon_tdata[HDR_W-1:0]);

    pkt_stat_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (beat),
        .last       (mon_tlast),
        .has_ts_bit (hdr_now.has_ts),
        .hdr_beat   (hdr_beat),
        .ts_beat    (ts_beat),
        .pay_beat   (pay_beat),
        .pkt_end    (pkt_end)
    );

    pkt_stat_accum #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (pay_beat),
        .clear     (pkt_end),
        .din       (mon_tdata),
        .nxt_count (a_count),
        .nxt_sum   (a_sum),
        .nxt_min   (a_min),
        .nxt_max   (a_max),
        .nxt_xor   (a_xor)
    );

    // Header and timestamp latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q <= '0;
            ts_q  <= '0;
        end else if (hdr_beat) begin
            hdr_q <= hdr_now;
            ts_q  <= '0;
        end else if (ts_beat) begin
            ts_q  <= mon_tdata;
        end
    end

    // A packet may end on its header or timestamp beat: take those live.
    assign hdr_sel = hdr_beat ? hdr_now : hdr_q;
    assign ts_sel  = ts_beat ? mon_tdata : (hdr_beat ? '0 : ts_q);

    // Report registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stats_valid   <= 1'b0;
            rpt_kind      <= '0;
            rpt_has_ts    <= 1'b0;
            rpt_end_burst <= 1'b0;
            rpt_seq       <= '0;
            rpt_len       <= '0;
            rpt_src       <= '0;
            rpt_dst       <= '0;
            rpt_ts        <= '0;
            rpt_count     <= '0;
            rpt_sum       <= '0;
            rpt_min       <= '0;
            rpt_max       <= '0;
            rpt_xor       <= '0;
        end else begin
            stats_valid <= pkt_end;
            if (pkt_end) begin
                rpt_kind      <= hdr_sel.kind;
                rpt_has_ts    <= hdr_sel.has_ts;
                rpt_end_burst <= hdr_sel.end_burst;
                rpt_seq       <= hdr_sel.seq;
                rpt_len       <= hdr_sel.len;
                rpt_src       <= hdr_sel.src;
                rpt_dst       <= hdr_sel.dst;
                rpt_ts        <= ts_sel;
                rpt_count     <= a_count;
                rpt_sum       <= a_sum;
                rpt_min       <= a_min;
                rpt_max       <= a_max;
                rpt_xor       <= a_xor;
            end
        end
    end

    AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_tvalid && mon_tready && mon_tlast) |=> stats_valid); // R8

    AST_STROBE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        !(mon_tvalid && mon_tready && mon_tlast) |=> !stats_valid); // R8

    AST_EMPTY_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (stats_valid && rpt_count == '0) |->
            (rpt_sum == '0 && rpt_xor == '0 && rpt_max == '0 && rpt_min == MIN_INIT)); // R9

    AST_NO_TS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stats_valid && !rpt_has_ts) |-> (rpt_ts == '0)); // R3

    AST_REPORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mon_tvalid && mon_tready && mon_tlast) |=> $stable(rpt_count) && $stable(rpt_sum)); // R8

endmodule

// File: tb/pkt_stat_monitor_bench.sv
module pkt_stat_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] MIN_INIT = 64'h7FFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic        has_ts;
        logic [3:0]  npay;
        logic [63:0] base;
        logic [63:0] step;
        logic        stall;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'd4, 64'd10,                   64'd3,                   1'b0},
        '{1'b1, 4'd5, 64'h8000_0000_0000_0000, 64'h0000_0001_0000_0001, 1'b1},
        '{1'b0, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0,                   1'b0},
        '{1'b1, 4'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'd8,                   1'b0},
        '{1'b0, 4'd6, 64'd100,                  64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
        '{1'b1, 4'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1,                   1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] mon_tdata = '0;
    logic        mon_tvalid = 1'b0;
    logic        mon_tready = 1'b0;
    logic        mon_tlast = 1'b0;
    logic        stats_valid;
    logic [1:0]  rpt_kind;
    logic        rpt_has_ts, rpt_end_burst;
    logic [11:0] rpt_seq;
    logic [15:0] rpt_len, rpt_src, rpt_dst;
    logic [63:0] rpt_ts;
    logic [31:0] rpt_count;
    logic [63:0] rpt_sum, rpt_min, rpt_max, rpt_xor;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_stat_monitor u_pkt_stat_monitor (
        .clk(clk), .rst_n(rst_n),
        .mon_tdata(mon_tdata), .mon_tvalid(mon_tvalid),
        .mon_tready(mon_tready), .mon_tlast(mon_tlast),
        .stats_valid(stats_valid), .rpt_kind(rpt_kind), .rpt_has_ts(rpt_has_ts),
        .rpt_end_burst(rpt_end_burst), .rpt_seq(rpt_seq), .rpt_len(rpt_len),
        .rpt_src(rpt_src), .rpt_dst(rpt_dst), .rpt_ts(rpt_ts),
        .rpt_count(rpt_count), .rpt_sum(rpt_sum), .rpt_min(rpt_min),
        .rpt_max(rpt_max), .rpt_xor(rpt_xor)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One accepted beat; optionally preceded by a refused beat and followed by a gap.
    task automatic put_beat(input logic [63:0] d, input logic last, input logic stall);
        if (stall) begin
            mon_tvalid = 1'b1; mon_tready = 1'b0; mon_tdata = ~d; mon_tlast = 1'b1;
            @(negedge clk);
        end
        mon_tvalid = 1'b1; mon_tready = 1'b1; mon_tdata = d; mon_tlast = last;
        @(posedge clk);
        @(negedge clk);
        mon_tvalid = 1'b0; mon_tlast = 1'b0;
        if (stall && !last) begin
            mon_tdata = 64'hDEAD_BEEF_DEAD_BEEF; mon_tlast = 1'b1;
            @(negedge clk);
            mon_tlast = 1'b0;
        end
    endtask

    // Sends a packet; returns at the negedge where its report strobe is visible.
    task automatic send_pkt(input logic [63:0] hdr, input logic [63:0] ts, input int npay,
                            input logic [63:0] base, input logic [63:0] step, input logic stall);
        logic has_t;
        has_t = hdr[61];
        put_beat(hdr, (npay == 0) && !has_t, stall);
        if (has_t) put_beat(ts, npay == 0, stall);
        for (int i = 0; i < npay; i++)
            put_beat(base + 64'(i) * step, i == npay - 1, stall);
    endtask

    task automatic check_report(input string tag, input logic [63:0] hdr, input logic [63:0] ts,
                                input int npay, input logic [63:0] base, input logic [63:0] step);
        logic [63:0] s, x, mn, mx, w;
        s = '0; x = '0; mn = MIN_INIT; mx = '0;
        for (int i = 0; i < npay; i++) begin
            w = base + 64'(i) * step;
            s = s + w; x = x ^ w;
            if (w < mn) mn = w;
            if (w > mx) mx = w;
        end
        chk({tag, " R8"}, "stats_valid", {63'd0, stats_valid}, 64'd1);
        chk({tag, " R2"}, "kind",   {62'd0, rpt_kind},      {62'd0, hdr[63:62]});
        chk({tag, " R2"}, "has_ts", {63'd0, rpt_has_ts},    {63'd0, hdr[61]});
        chk({tag, " R2"}, "eob",    {63'd0, rpt_end_burst}, {63'd0, hdr[60]});
        chk({tag, " R2"}, "seq",    {52'd0, rpt_seq},       {52'd0, hdr[59:48]});
        chk({tag, " R2"}, "len",    {48'd0, rpt_len},       {48'd0, hdr[47:32]});
        chk({tag, " R2"}, "src",    {48'd0, rpt_src},       {48'd0, hdr[31:16]});
        chk({tag, " R2"}, "dst",    {48'd0, rpt_dst},       {48'd0, hdr[15:0]});
        chk({tag, " R3"}, "ts",     rpt_ts,                 hdr[61] ? ts : 64'd0);
        chk({tag, " R4"}, "count",  {32'd0, rpt_count},     64'(npay));
        chk({tag, " R5"}, "sum",    rpt_sum,                s);
        chk({tag, " R6"}, "min",    rpt_min,                mn);
        chk({tag, " R6"}, "max",    rpt_max,                mx);
        chk({tag, " R7"}, "xor",    rpt_xor,                x);
    endtask

    function automatic logic [63:0] mk_hdr(input int k, input logic ht);
        return {2'(k), ht, 1'(k), 12'(k + 1), 16'(8 * k + 24), 16'hA000 + 16'(k), 16'h0B00 | 16'(k)};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] h, ha, hb, hc;
        repeat (3) @(negedge clk);
        // Reset state, R8
        chk("reset R8", "stats_valid", {63'd0, stats_valid}, 64'd0);
        chk("reset R8", "count", {32'd0, rpt_count}, 64'd0);
        chk("reset R8", "min", rpt_min, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven packets
        for (int k = 0; k < NVEC; k++) begin
            h = mk_hdr(k, VECS[k].has_ts);
            send_pkt(h, 64'h1234_0000_0000_0000 + 64'(k), int'(VECS[k].npay),
                     VECS[k].base, VECS[k].step, VECS[k].stall);
            check_report($sformatf("vec%0d", k), h, 64'h1234_0000_0000_0000 + 64'(k),
                         int'(VECS[k].npay), VECS[k].base, VECS[k].step);
            @(negedge clk);
            chk("strobe width R8", "stats_valid", {63'd0, stats_valid}, 64'd0);
            chk("hold R8", "count", {32'd0, rpt_count}, 64'(VECS[k].npay));
        end

        // Header-only packet, R9
        h = mk_hdr(9, 1'b0);
        send_pkt(h, 64'd0, 0, 64'd0, 64'd0, 1'b0);
        check_report("hdr_only R9", h, 64'd0, 0, 64'd0, 64'd0);
        @(negedge clk);

        // Header plus timestamp only, R9 and R3
        h = mk_hdr(10, 1'b1);
        send_pkt(h, 64'h0FED_CBA9_8765_4321, 0, 64'd0, 64'd0, 1'b1);
        check_report("ts_only R9", h, 64'h0FED_CBA9_8765_4321, 0, 64'd0, 64'd0);
        @(negedge clk);

        // Back-to-back: next header in the strobe cycle, R10
        ha = mk_hdr(11, 1'b0);
        hb = mk_hdr(12, 1'b0);
        hc = mk_hdr(13, 1'b1);
        send_pkt(ha, 64'd0, 3, 64'hF000_0000_0000_0001, 64'd5, 1'b0);
        check_report("b2b_a R10", ha, 64'd0, 3, 64'hF000_0000_0000_0001, 64'd5);
        send_pkt(hb, 64'd0, 0, 64'd0, 64'd0, 1'b0);
        check_report("b2b_b R10", hb, 64'd0, 0, 64'd0, 64'd0);
        send_pkt(hc, 64'h55, 1, 64'd7, 64'd0, 1'b0);
        check_report("b2b_c R10", hc, 64'h55, 1, 64'd7, 64'd0);
        @(negedge clk);
        chk("b2b_end R8", "stats_valid", {63'd0, stats_valid}, 64'd0);

        // Refused beats only: nothing reported, R1
        mon_tvalid = 1'b1; mon_tready = 1'b0; mon_tlast = 1'b1; mon_tdata = 64'hABCD;
        repeat (3) @(negedge clk);
        mon_tvalid = 1'b0; mon_tlast = 1'b0;
        @(negedge clk);
        chk("refused R1", "stats_valid", {63'd0, stats_valid}, 64'd0);
        chk("refused R1", "count", {32'd0, rpt_count}, 64'd1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule